// File: doc/BRIEF.md
# Control-Word Square-Wave Synthesizer

This block turns a fixed reference clock into a slower square wave whose rate is set by a 16-bit control word. It holds a 16-bit phase accumulator. On every reference cycle while the run input is high, the accumulator adds an effective increment. The square wave is the most significant bit of the accumulator, so its frequency is W / 65536 times the reference frequency. With a nominal 27 MHz reference, a word of 0x0100 gives about 105 kHz.

Words below half scale are used unchanged. Words at or above half scale are replaced by their 16-bit two's complement before they are added, so both 0x4000 and 0xC000 step by 0x4000. The word is written as two bytes. The upper byte is kept in a holding register. Writing the lower byte moves the full 16-bit word into the working register in one step, so the accumulator never sees half of an old word and half of a new one.

Alongside the square wave, the block gives a one-cycle tick on each rising edge of the wave. A downstream fixed-frequency stage can use this tick as its clock enable. A power-of-two word (1 up to 32768) gives an exact 50% duty wave, which is the use the block is meant for.

Top module: `cw_freq_gen`

## Requirements
- R1: While reset is asserted and after it is released, the square wave and the tick are low, and the working word and the upper-byte holding register read as zero.
- R2: A write to the upper byte alone does not change the increment that the accumulator uses.
- R3: A write to the lower byte loads the working word with the held upper byte in bits 15:8 and the written byte in bits 7:0. If both bytes are written in the same cycle, the new upper byte is used. The new word is used from the accumulation that follows the write edge.
- R4: The effective increment is the working word when the word is below 0x8000. Otherwise it is 0x10000 minus the word, so 0x8000 gives 0x8000 and 0xFFFF gives 1.
- R5: While run is low, the accumulator is zero. From the next cycle on, the square wave is low and no tick is produced.
- R6: While run is high, the accumulator adds the effective increment modulo 2^16 on each reference cycle, and the square wave equals accumulator bit 15.
- R7: For a word of 2^k (0 ≤ k ≤ 15), starting from a zero accumulator, the square wave has a period of exactly 2^(16-k) cycles and is high for exactly half of them.
- R8: The tick is high for exactly one cycle: the first cycle in which the square wave is high after being low. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run | input | 1 | Run enable; low holds the accumulator at zero |
| wr_upper | input | 1 | Strobe: write wr_byte into the upper-byte holding register |
| wr_lower | input | 1 | Strobe: write wr_byte as the lower byte and load the full working word |
| wr_byte | input | 8 | Byte data for either write strobe |
| sq_out | output | 1 | Square-wave output (accumulator bit 15) |
| tick_out | output | 1 | One-cycle pulse on each rising edge of sq_out |

## Verification
The hardest case to reach from the ports is a lower-byte write that lands in the same cycle as an upper-byte write. In that case the new upper byte must win over the held one. The stimulus first leaves a different upper byte in the holding register, then writes 0x08 on both strobes in one cycle, and times the first tick after run rises. The word 0x0808 and the wrongly combined word 0x1008 reach half scale after different numbers of cycles, so the two outcomes are told apart. A second pair of cases checks the two folding extremes and the write that changes only the upper byte. Each of these is followed by a period measurement, so an effect shows up at the wave output.

// File: rtl/cwfg_pkg.sv
package cwfg_pkg;
  localparam int unsigned CWFG_WORD_W = 16;
  localparam int unsigned CWFG_BYTE_W = CWFG_WORD_W / 2;
  typedef logic [CWFG_WORD_W-1:0] cwfg_word_t;
  typedef logic [CWFG_BYTE_W-1:0] cwfg_byte_t;
endpackage

// File: rtl/cwfg_rst_sync.sv
module cwfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cwfg_word_regs.sv
module cwfg_word_regs #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_upper,
  input  logic              wr_lower,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              hold_en, word_en;

  always_comb begin
    hold_en = wr_upper;
    hold_d  = wr_byte;
    word_en = wr_lower;
    // same-cycle upper write takes priority over the held byte
    word_d  = {(wr_upper ? wr_byte : hold_q), wr_byte};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign word = word_q;

  p_upper_only_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lower |=> $stable(word_q));

  p_lower_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lower |=> (word_q[BYTE_W-1:0] == $past(wr_byte)));
endmodule

// File: rtl/cwfg_fold.sv
module cwfg_fold #(
  parameter int unsigned WORD_W  = 16,
  parameter bit          FOLD_EN = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] inc
);
  localparam int unsigned MSB = WORD_W - 1;

  generate
    if (FOLD_EN) begin : g_fold
      always_comb begin
        if (word[MSB]) inc = (~word) + {{(WORD_W-1){1'b0}}, 1'b1};
        else           inc = word;
      end
    end else begin : g_plain
      always_comb inc = word;
    end
  endgenerate

  // increment never exceeds half scale
  always_comb begin
    p_inc_half_scale_r4: assert (!inc[MSB] || (inc[MSB-1:0] == '0));
  end
endmodule

// File: rtl/cwfg_accum.sv
module cwfg_accum #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WORD_W-1:0] inc,
  output logic              sq,
  output logic              tick
);
  localparam int unsigned MSB = WORD_W - 1;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic              tick_q, tick_d;
  logic              acc_en;

  always_comb begin
    acc_d  = run ? (acc_q + inc) : '0;
    acc_en = run | (|acc_q);
    tick_d = ~acc_q[MSB] & acc_d[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign sq   = acc_q[MSB];
  assign tick = tick_q;

  p_run_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((acc_q == '0) && !tick_q));

  p_accum_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (acc_q == WORD_W'($past(acc_q) + $past(inc))));

  p_tick_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q == (acc_q[MSB] && !$past(acc_q[MSB])));

  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/cw_freq_gen.sv
module cw_freq_gen
  import cwfg_pkg::*;
(
  input  logic                   clk_ref,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   wr_upper,
  input  logic                   wr_lower,
  input  logic [CWFG_BYTE_W-1:0] wr_byte,
  output logic                   sq_out,
  output logic                   tick_out
);
  logic       srst_n;
  cwfg_word_t word;
  cwfg_word_t inc;

  cwfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_ref),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cwfg_word_regs #(.WORD_W(CWFG_WORD_W)) u_regs (
    .clk      (clk_ref),
    .rst_n    (srst_n),
    .wr_upper (wr_upper),
    .wr_lower (wr_lower),
    .wr_byte  (wr_byte),
    .word     (word)
  );

  cwfg_fold #(.WORD_W(CWFG_WORD_W), .FOLD_EN(1'b1)) u_fold (
    .word (word),
    .inc  (inc)
  );

  cwfg_accum #(.WORD_W(CWFG_WORD_W)) u_acc (
    .clk   (clk_ref),
    .rst_n (srst_n),
    .run   (run),
    .inc   (inc),
    .sq    (sq_out),
    .tick  (tick_out)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_ref)
    !srst_n |=> (!sq_out && !tick_out));
endmodule

// File: tb/test_cw_freq_gen.sv
module test_cw_freq_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       wr_upper = 1'b0;
  logic       wr_lower = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       sq_out, tick_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit lockstep = 1'b0;
  bit done     = 1'b0;

  logic [15:0] m_acc = '0, m_word = '0;
  logic [7:0]  m_hold = '0;
  logic        m_tick = 1'b0;

  cw_freq_gen i_cw_freq_gen (
    .clk_ref  (clk_ref_w),
    .rst_n    (rst_n),
    .run      (run),
    .wr_upper (wr_upper),
    .wr_lower (wr_lower),
    .wr_byte  (wr_byte),
    .sq_out   (sq_out),
    .tick_out (tick_out)
  );
  wire clk_ref_w = clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] eff_inc(input logic [15:0] w);
    logic [16:0] t;
    t = w[15] ? (17'h10000 - {1'b0, w}) : {1'b0, w};
    return t[15:0];
  endfunction

  // reference model built from the requirements
  always @(posedge clk) begin
    logic [15:0] nxt;
    logic [7:0]  hold_old;
    if (!rst_n) begin
      m_acc = '0; m_word = '0; m_hold = '0; m_tick = 1'b0;
    end else begin
      nxt = run ? 16'(m_acc + eff_inc(m_word)) : 16'h0;  // R4 R6
      m_tick = ~m_acc[15] & nxt[15];                    // R8
      m_acc = nxt;
      hold_old = m_hold;
      if (wr_upper) m_hold = wr_byte;
      if (wr_lower) m_word = {wr_upper ? wr_byte : hold_old, wr_byte};
    end
    cycles++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (lockstep && rst_n) begin
      check("R6 lockstep sq", int'(sq_out), int'(m_acc[15]));
      check("R8 lockstep tick", int'(tick_out), int'(m_tick));
    end
  end

  task automatic write_upper(input logic [7:0] b);
    wr_upper = 1'b1; wr_byte = b;
    @(negedge clk); wr_upper = 1'b0;
  endtask

  task automatic write_lower(input logic [7:0] b);
    wr_lower = 1'b1; wr_byte = b;
    @(negedge clk); wr_lower = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] w);
    write_upper(w[15:8]);
    write_lower(w[7:0]);
  endtask

  task automatic restart();
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    run = 1'b1;
  endtask

  task automatic measure(input string req, input int exp_period);
    int per, hi;
    while (tick_out !== 1'b1) @(negedge clk);
    per = 1; hi = 1;
    forever begin
      @(negedge clk);
      if (tick_out === 1'b1) break;
      per++;
      if (sq_out === 1'b1) hi++;
    end
    check({req, " period"}, per, exp_period);
    check({req, " high time"}, hi, exp_period / 2);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset
    repeat (3) @(negedge clk);
    check("R1 sq in reset", int'(sq_out), 0);
    check("R1 tick in reset", int'(tick_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sq after reset", int'(sq_out), 0);
    check("R1 tick after reset", int'(tick_out), 0);
    lockstep = 1'b1;

    // R1: working word is zero after reset -> run gives no ticks
    run = 1'b1;
    n = 0;
    repeat (40) begin @(negedge clk); if (tick_out) n++; end
    check("R1 zero word no ticks", n, 0);

    // R5: run low with a fast word loaded
    run = 1'b0;
    write_word(16'h4000);
    n = 0;
    repeat (40) begin @(negedge clk); if (tick_out || sq_out) n++; end
    check("R5 idle while run low", n, 0);

    // R7: sweep powers of two, largest first
    for (int k = 15; k >= 2; k--) begin
      run = 1'b0;
      write_word(16'(1 << k));
      restart();
      measure($sformatf("R7 word 2^%0d", k), 1 << (16 - k));
    end

    // R5: dropping run clears the wave on the next cycle
    run = 1'b0;
    @(negedge clk);
    check("R5 sq after run drop", int'(sq_out), 0);

    // R4: folded words
    write_word(16'hC000);
    restart();
    measure("R4 word 0xC000", 4);
    run = 1'b0;
    write_word(16'hFF00);
    restart();
    measure("R4 word 0xFF00", 256);
    run = 1'b0;
    write_word(16'h8000);
    restart();
    measure("R4 word 0x8000", 2);

    // R2: upper byte alone keeps the old increment
    run = 1'b0;
    write_word(16'h0400);
    write_upper(8'h10);
    restart();
    measure("R2 upper-only write", 64);

    // R3: lower byte completes the word 0x1000
    run = 1'b0;
    write_lower(8'h00);
    restart();
    measure("R3 lower write loads word", 16);

    // R3: same-cycle write, word 0x0808 -> first tick after 16 steps
    run = 1'b0;
    wr_upper = 1'b1; wr_lower = 1'b1; wr_byte = 8'h08;
    @(negedge clk);
    wr_upper = 1'b0; wr_lower = 1'b0;
    @(negedge clk);
    run = 1'b1;
    n = 0;
    repeat (64) begin
      @(negedge clk); n++;
      if (tick_out) break;
    end
    check("R3 same-cycle upper wins", n, 16);

    // R6: non-power word exercised in lockstep
    repeat (300) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule